// File: doc/BRIEF.md
# Handshaked Byte-to-Packet Assembler

This block builds a wide packet out of single bytes delivered over a request/acknowledge channel. Each byte the block takes is pushed into the least significant byte of a packet register. Everything already in the register moves up one byte, and the most significant byte falls off the end. An 8-bit counter records how many bytes of the current packet have arrived.

Once the counter reaches the number of bytes in a packet, the register is offered downstream on a valid/ready port. While that offer is pending, the byte channel is closed. A transfer clears the counter and reopens the channel. The register itself is not cleared, so the next packet pushes the old contents out byte by byte.

On the byte channel, the source raises request with a byte and holds it until acknowledge appears. The block answers each accepted byte with a single-cycle acknowledge. The source drops request on seeing acknowledge.

Top module: `pkt_assembler`

## Requirements
- R1: While rst_ni is low, and after it is released, byte_ack_o is 0, pkt_valid_o is 0 and pkt_data_o is all zeros.
- R2: A byte is accepted in a cycle where byte_req_i is 1, byte_ack_o is 0 and the packet is not complete. byte_ack_o is 1 in the following cycle.
- R3: byte_ack_o is never high for two consecutive cycles. Holding byte_req_i high during the acknowledge cycle adds no byte.
- R4: An accepted byte lands in pkt_data_o[7:0]. Each older byte moves up by 8 bit positions and the top byte is discarded, so the first byte of a complete packet sits in the most significant byte.
- R5: pkt_valid_o rises in the cycle after the (PKT_W/8)-th byte of a packet is accepted. PKT_W must be a multiple of 8, at most 2040.
- R6: While pkt_valid_o is 1, no byte is accepted. byte_ack_o stays 0 and pkt_data_o does not change, whatever byte_req_i does.
- R7: A packet transfers in a cycle where pkt_valid_o and pkt_ready_i are both 1. pkt_valid_o is 0 in the next cycle and the byte count restarts from zero.
- R8: While pkt_valid_o is 1 and pkt_ready_i is 0, pkt_valid_o stays 1 and pkt_data_o stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_req_i | input | 1 | Byte request from the source |
| byte_data_i | input | 8 | Byte offered with the request |
| byte_ack_o | output | 1 | Single-cycle acknowledge of an accepted byte |
| pkt_valid_o | output | 1 | Complete packet offered downstream |
| pkt_ready_i | input | 1 | Downstream can take the packet |
| pkt_data_o | output | PKT_W | Packet register contents |

## Verification
Several properties are checked on every cycle:
- the acknowledge that follows each acceptance and its single-cycle width;
- the closed byte channel while a packet is pending;
- the stability of a stalled packet;
- the drop of valid after a transfer;
- the bound on the byte counter.

Only the bench's scenarios can show that the bytes land in the right order, that a packet completes after exactly PKT_W/8 bytes, and how old contents shift out during a partially built second packet.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/byte_hs_rx.sv
module byte_hs_rx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hold_i,
  output logic ack_o,
  output logic take_o
);
  logic ack_q;

  assign take_o = req_i && !ack_q && !hold_i;
  assign ack_o  = ack_q;

  // ack is a one-cycle answer to each accepted byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= take_o;
  end

  // R3
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  // R2
  ack_follows_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_q && !hold_i) |=> ack_q);
endmodule

// File: rtl/byte_counter.sv
module byte_counter
  import pkt_asm_pkg::*;
#(
  parameter int unsigned BYTES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic clear_i,
  output logic full_o
);
  localparam cnt_t LAST = cnt_t'(BYTES);

  cnt_t cnt_q;

  assign full_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (take_i)  cnt_q <= cnt_q + cnt_t'(1);
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R6
  no_take_when_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_i && clear_i));
endmodule

// File: rtl/pkt_shift_reg.sv
module pkt_shift_reg
  import pkt_asm_pkg::*;
#(
  parameter int unsigned PKT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  byte_t            byte_i,
  output logic [PKT_W-1:0] pkt_o
);
  localparam int unsigned LANES = PKT_W / BYTE_W;

  byte_t lane_q [LANES];

  // lane 0 loads the new byte, lane k takes lane k-1; the top lane is dropped
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lane_q[k] <= '0;
      else if (take_i) lane_q[k] <= (k == 0) ? byte_i : lane_q[(k == 0) ? 0 : k-1];
    end
    assign pkt_o[k*BYTE_W +: BYTE_W] = lane_q[k];
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(pkt_o));
endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler
  import pkt_asm_pkg::*;
#(
  parameter int unsigned PKT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_req_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ack_o,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic [PKT_W-1:0] pkt_data_o
);
  localparam int unsigned BYTES = PKT_W / BYTE_W;

  logic take, full, xfer;

  assign pkt_valid_o = full;
  assign xfer        = full && pkt_ready_i;

  byte_hs_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (byte_req_i),
    .hold_i (full),
    .ack_o  (byte_ack_o),
    .take_o (take)
  );

  byte_counter #(.BYTES(BYTES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .clear_i (xfer),
    .full_o  (full)
  );

  pkt_shift_reg #(.PKT_W(PKT_W)) u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .byte_i (byte_data_i),
    .pkt_o  (pkt_data_o)
  );

  // R6
  closed_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !byte_ack_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

  // R7
  xfer_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i) |=> !pkt_valid_o);
endmodule

// File: tb/pkt_assembler_tb_top.sv
module pkt_assembler_tb_top;
  localparam int unsigned PKT_W = 64;
  localparam int unsigned NB    = PKT_W / 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic [7:0]       din = '0;
  logic             ack;
  logic             valid;
  logic             ready = 1'b0;
  logic [PKT_W-1:0] dout;
  logic [PKT_W-1:0] exp_reg = '0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pkt_assembler #(.PKT_W(PKT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_req_i(req), .byte_data_i(din),
    .byte_ack_o(ack), .pkt_valid_o(valid), .pkt_ready_i(ready), .pkt_data_o(dout)
  );

  task automatic chk(input string req_tag, input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  // one four-phase byte; checks R2 ack and R3 single-cycle ack
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    req = 1'b1; din = b;
    @(negedge clk);
    chk("R2", ack, 1);
    exp_reg = {exp_reg[PKT_W-9:0], b};
    @(negedge clk);
    chk("R3", ack, 0);
    req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", ack, 0); chk("R1", valid, 0); chk("R1", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ack, 0); chk("R1", valid, 0); chk("R1", dout, 0);
    exp_reg = '0;
  endtask

  task automatic t_fill(input logic [7:0] base);
    for (int i = 0; i < NB; i++) begin
      chk("R5", valid, 0);
      send_byte(base + 8'(i));
    end
    chk("R5", valid, 1);
    chk("R4", dout, exp_reg);
    chk("R4", dout[PKT_W-1 -: 8], base);
  endtask

  task automatic t_backpressure();
    logic [PKT_W-1:0] snap;
    snap = dout;
    @(negedge clk);
    req = 1'b1; din = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6", ack, 0);
      chk("R8", valid, 1);
      chk("R6", dout, snap);
    end
    req = 1'b0;
  endtask

  task automatic t_transfer();
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R7", valid, 0);
    chk("R7", dout, exp_reg);
  endtask

  // second packet: old bytes move up while new ones enter
  task automatic t_partial_shift();
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    chk("R4", dout, exp_reg);
    chk("R4", dout[23:0], 24'hA1B2C3);
    chk("R7", valid, 0);
    for (int i = 3; i < NB; i++) send_byte(8'h50 + 8'(i));
    chk("R7", valid, 1);
    chk("R4", dout, exp_reg);
  endtask

  // request held high through the ack cycle adds exactly one byte
  task automatic t_held_req();
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    req = 1'b1; din = 8'h77;
    @(negedge clk);
    chk("R2", ack, 1);
    exp_reg = {exp_reg[PKT_W-9:0], 8'h77};
    req = 1'b1;
    @(negedge clk);
    chk("R3", ack, 0);
    req = 1'b0;
    @(negedge clk);
    chk("R3", dout, exp_reg);
    for (int i = 1; i < NB; i++) begin
      chk("R3", valid, 0);
      send_byte(8'h10 + 8'(i));
    end
    chk("R3", valid, 1);
  endtask

  initial begin
    t_reset();
    t_fill(8'h01);
    t_backpressure();
    t_transfer();
    t_partial_shift();
    t_held_req();
    t_reset();
    finish_run();
  end
endmodule